// File: doc/BRIEF.md
# Masked SIMD Processing Element

This block is one 16-bit lane of a SIMD array. Many copies sit side by side under one sequencer, and every copy receives the same decoded control fields in the same cycle. In each cycle a lane reads a first operand from its own 16-word register file. The second operand comes either from that register file or from an array-wide broadcast bus. The lane then computes an arithmetic or logic result. It can write that result back locally, drive it onto the broadcast bus, or do both.

Each lane holds an activity flag. A lane whose flag is low does not write to its register file and does not drive the bus, so the sequencer can run conditional code across the array without branching. A compare step loads the flag from the zero or sign condition of the current result. Only lanes that are already active can change their flag, so conditions nest by narrowing the active set. A separate clear-all control makes every lane active again.

The bus output is zero whenever the lane does not drive it, so the outputs of many lanes can be combined with an OR tree or a multiplexer.

Top module: `simd_pe`

## Requirements
- R1: Opcode 0 (add) produces ra + B modulo 2^16.
- R2: Opcode 1 (subtract) produces ra - B modulo 2^16.
- R3: Opcodes 2, 3 and 4 produce the bitwise AND, OR and XOR of ra and B. Opcode 5 passes B through unchanged. Opcodes 6 and 7 produce zero.
- R4: When src_b_sel is 1, operand B is bus_in. When src_b_sel is 0, operand B is the register addressed by rb. Register reads are combinational.
- R5: When wb_en is high and the lane is active, the result is written to register rd at the next rising edge. It can be read back in the cycle after that edge.
- R6: While the lane is inactive, no register changes, even with wb_en high.
- R7: bus_oe is high exactly when bus_drive_en is high and the lane is active. bus_out equals the result when bus_oe is high and is zero otherwise.
- R8: When set_flag is high and the lane is active, the flag is loaded at the next edge. With flag_cond = 0 it takes the value (result == 0); with flag_cond = 1 it takes result bit 15. An inactive lane ignores set_flag.
- R9: flag_clear_all sets the flag at the next edge and takes priority over set_flag.
- R10: Synchronous reset sets the flag to 1. With no reset, no clear and no applicable set_flag, the flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flag_clear_all | input | 1 | Makes the lane active at the next edge |
| op | input | 3 | Operation code |
| rd | input | 4 | Write register address |
| ra | input | 4 | Operand A register address |
| rb | input | 4 | Operand B register address |
| src_b_sel | input | 1 | 1 selects bus_in as operand B |
| wb_en | input | 1 | Request to write the result to rd |
| bus_drive_en | input | 1 | Request to drive the result onto the bus |
| set_flag | input | 1 | Load the flag from the result condition |
| flag_cond | input | 1 | 0 selects the zero condition, 1 selects the sign condition |
| bus_in | input | 16 | Broadcast bus value |
| bus_out | output | 16 | Result driven to the bus, or zero |
| bus_oe | output | 1 | The lane is driving the bus |
| active | output | 1 | Activity flag |

## Verification
The bench builds the lane with its default parameters: 16-bit data, 16 registers and the shared add/subtract adder. With 16 registers, every register can be written and read back, and every opcode code from 0 to 7 can be applied, including the two unused codes. Each opcode is swept over many operand pairs taken from both B sources, and the expected values are computed with plain arithmetic. Wrap-around at 0xFFFF is checked. The flag tests cover each way the flag can change state and each way it must stay unchanged, including the priority of clear-all over set_flag.

// File: rtl/pe_pkg.sv
package pe_pkg;
   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_ADD   = 3'd0,
      OP_SUB   = 3'd1,
      OP_AND   = 3'd2,
      OP_OR    = 3'd3,
      OP_XOR   = 3'd4,
      OP_PASSB = 3'd5
   } pe_op_e;
endpackage

// File: rtl/pe_regfile.sv
module pe_regfile #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 16,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [AW-1:0]     wa,
   input  logic [DATA_W-1:0] wd,
   input  logic [AW-1:0]     ra_a,
   input  logic [AW-1:0]     ra_b,
   output logic [DATA_W-1:0] rdata_a,
   output logic [DATA_W-1:0] rdata_b
);
   logic [DEPTH-1:0][DATA_W-1:0] mem;

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (we && (wa == AW'(i))) word_q <= wd;
      end
      assign mem[i] = word_q;
   end

   assign rdata_a = mem[ra_a];
   assign rdata_b = mem[ra_b];

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
      we |=> (mem[$past(wa)] == $past(wd)));   // R5
   AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
      !we |=> $stable(mem));                   // R6
endmodule

// File: rtl/pe_alu.sv
module pe_alu
   import pe_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] result
);
   logic [DATA_W-1:0] sum;

   if (SHARED_ADDER) begin : g_shared
      logic sub;
      assign sub = (op == OP_SUB);
      assign sum = a + (b ^ {DATA_W{sub}}) + DATA_W'(sub);
   end else begin : g_split
      assign sum = (op == OP_SUB) ? (a - b) : (a + b);
   end

   always_comb begin
      case (op)
         OP_ADD, OP_SUB: result = sum;
         OP_AND:         result = a & b;
         OP_OR:          result = a | b;
         OP_XOR:         result = a ^ b;
         OP_PASSB:       result = b;
         default:        result = '0;
      endcase
   end
endmodule

// File: rtl/pe_flag.sv
module pe_flag #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr_all,
   input  logic              set_flag,
   input  logic              cond_sel,
   input  logic [DATA_W-1:0] result,
   output logic              active
);
   logic cond;

   assign cond = cond_sel ? result[DATA_W-1] : (result == '0);

   always_ff @(posedge clk) begin
      if (rst)                     active <= 1'b1;
      else if (clr_all)            active <= 1'b1;
      else if (set_flag && active) active <= cond;
   end

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
      clr_all |=> active);                                  // R9
   AST_ASLEEP_STAYS: assert property (@(posedge clk) disable iff (rst)
      (!active && !clr_all) |=> !active);                   // R8
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!clr_all && !set_flag) |=> $stable(active));         // R10
endmodule

// File: rtl/simd_pe.sv
module simd_pe
   import pe_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int REGS         = 16,
   parameter bit SHARED_ADDER = 1'b1,
   localparam int ADDR_W      = $clog2(REGS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              flag_clear_all,
   input  logic [OP_W-1:0]   op,
   input  logic [ADDR_W-1:0] rd,
   input  logic [ADDR_W-1:0] ra,
   input  logic [ADDR_W-1:0] rb,
   input  logic              src_b_sel,
   input  logic              wb_en,
   input  logic              bus_drive_en,
   input  logic              set_flag,
   input  logic              flag_cond,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   output logic              active
);
   if (DATA_W < 2) begin : g_bad_width
      $error("simd_pe: DATA_W must be at least 2");
   end
   if ((REGS < 2) || ((REGS & (REGS - 1)) != 0)) begin : g_bad_depth
      $error("simd_pe: REGS must be a power of two, at least 2");
   end

   logic [DATA_W-1:0] opa, reg_b, opb, result;
   logic              we;

   assign we = wb_en & active;

   pe_regfile #(.DATA_W(DATA_W), .DEPTH(REGS)) u_rf (
      .clk(clk), .rst(rst), .we(we), .wa(rd), .wd(result),
      .ra_a(ra), .ra_b(rb), .rdata_a(opa), .rdata_b(reg_b)
   );

   assign opb = src_b_sel ? bus_in : reg_b;

   pe_alu #(.DATA_W(DATA_W), .SHARED_ADDER(SHARED_ADDER)) u_alu (
      .op(op), .a(opa), .b(opb), .result(result)
   );

   pe_flag #(.DATA_W(DATA_W)) u_flag (
      .clk(clk), .rst(rst), .clr_all(flag_clear_all), .set_flag(set_flag),
      .cond_sel(flag_cond), .result(result), .active(active)
   );

   assign bus_oe  = bus_drive_en & active;
   assign bus_out = bus_oe ? result : '0;

   AST_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
      !bus_oe |-> (bus_out == '0));                        // R7
   AST_RESET_WAKES: assert property (@(posedge clk)
      rst |=> active);                                     // R10
endmodule

// File: tb/tb_simd_pe.sv
`timescale 1ns/100ps
module tb_simd_pe;
   localparam int DW = 16;
   localparam int NR = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          clr, src, wb, drv, setf, cnd;
   logic [2:0]    op;
   logic [3:0]    rd, ra, rb;
   logic [DW-1:0] busi;
   logic [DW-1:0] bus_out;
   logic          bus_oe, active;

   int            checks = 0;
   int            fails  = 0;
   logic [DW-1:0] model [NR];
   logic [DW-1:0] lfsr = 16'hACE1;

   always #2.5 clk = ~clk;

   simd_pe dut (
      .clk(clk), .rst(rst), .flag_clear_all(clr), .op(op), .rd(rd), .ra(ra),
      .rb(rb), .src_b_sel(src), .wb_en(wb), .bus_drive_en(drv),
      .set_flag(setf), .flag_cond(cnd), .bus_in(busi),
      .bus_out(bus_out), .bus_oe(bus_oe), .active(active)
   );

   function automatic logic [DW-1:0] f_alu(input logic [2:0] o,
                                           input logic [DW-1:0] a,
                                           input logic [DW-1:0] b);
      case (o)
         3'd0:    return a + b;
         3'd1:    return a - b;
         3'd2:    return a & b;
         3'd3:    return a | b;
         3'd4:    return a ^ b;
         3'd5:    return b;
         default: return '0;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      clr = 0; op = 3'd0; rd = 0; ra = 0; rb = 0; src = 0; wb = 0;
      drv = 0; setf = 0; cnd = 0; busi = '0;
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic next_rand();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   task automatic write_bus(input logic [3:0] r, input logic [DW-1:0] v);
      idle(); op = 3'd5; src = 1; busi = v; rd = r; wb = 1;
      step();
      model[r] = v;
   endtask

   task automatic read_check(input logic [3:0] r, input string req);
      idle(); op = 3'd5; src = 0; rb = r; drv = 1;
      #2;
      chk(req, bus_out, model[r]);
      step();
   endtask

   initial begin
      idle();
      step(); step();
      rst = 0;
      #1;
      chk("R10 reset active", active, 1);

      for (int r = 0; r < NR; r++) write_bus(4'(r), 16'(r * 16'h1357) ^ 16'hA5C3);
      for (int r = 0; r < NR; r++) read_check(4'(r), "R5 readback");

      // Opcode sweep, both B sources
      for (int o = 0; o < 8; o++) begin
         for (int k = 0; k < 24; k++) begin
            logic [DW-1:0] e;
            string tag;
            next_rand();
            idle();
            op = 3'(o); ra = 4'(k); rb = 4'(k * 7 + 3); src = k[0];
            busi = lfsr; rd = 4'(k + 5); wb = 1; drv = 1;
            e = f_alu(3'(o), model[ra], src ? busi : model[rb]);
            tag = (o == 0) ? "R1 add" : (o == 1) ? "R2 sub" : "R3 logic/pass";
            #2;
            chk(tag, bus_out, e);
            chk("R7 oe active", bus_oe, 1);
            step();
            model[4'(k + 5)] = e;
            read_check(4'(k + 5), "R5 write result");
         end
      end

      // Operand source select
      write_bus(4'd6, 16'h1234);
      idle(); op = 3'd5; rb = 4'd6; busi = 16'hBEEF; drv = 1; src = 1;
      #2; chk("R4 bus source", bus_out, 16'hBEEF);
      step();
      idle(); op = 3'd5; rb = 4'd6; busi = 16'hBEEF; drv = 1; src = 0;
      #2; chk("R4 reg source", bus_out, 16'h1234);
      step();

      // Wrap-around corners
      write_bus(4'd0, 16'hFFFF);
      write_bus(4'd1, 16'h0001);
      idle(); op = 3'd0; ra = 4'd0; rb = 4'd1; drv = 1;
      #2; chk("R1 wrap", bus_out, 16'h0000);
      step();
      idle(); op = 3'd1; ra = 4'd1; src = 1; busi = 16'h0003; drv = 1;
      #2; chk("R2 borrow", bus_out, 16'hFFFE);
      step();

      // Bus idle
      idle(); op = 3'd0; ra = 4'd0; rb = 4'd0; drv = 0;
      #2; chk("R7 idle out", bus_out, 0); chk("R7 idle oe", bus_oe, 0);
      step();

      // Flag behaviour
      idle(); op = 3'd1; ra = 4'd2; rb = 4'd2; setf = 1; cnd = 0;
      step(); chk("R8 zero keeps active", active, 1);
      idle(); op = 3'd5; src = 1; busi = 16'h8000; setf = 1; cnd = 1;
      step(); chk("R8 sign keeps active", active, 1);
      idle(); op = 3'd5; src = 1; busi = 16'h7FFF; setf = 1; cnd = 1;
      step(); chk("R8 sign clears", active, 0);

      idle(); op = 3'd5; src = 1; busi = 16'hDEAD; rd = 4'd3; wb = 1; drv = 1;
      #2; chk("R7 inactive oe", bus_oe, 0); chk("R7 inactive out", bus_out, 0);
      step();
      idle(); op = 3'd5; src = 1; busi = 16'h0000; setf = 1; cnd = 0;
      step(); chk("R8 inactive ignores set", active, 0);
      idle();
      step(); chk("R10 hold", active, 0);
      idle(); clr = 1; setf = 1; cnd = 0; op = 3'd5; src = 1; busi = 16'h0001;
      step(); chk("R9 clear over set", active, 1);
      read_check(4'd3, "R6 no write while inactive");

      idle(); op = 3'd5; src = 1; busi = 16'h0005; setf = 1; cnd = 0;
      step(); chk("R8 zero clears", active, 0);
      idle(); clr = 1;
      step(); chk("R9 clear", active, 1);
      idle(); op = 3'd5; src = 1; busi = 16'h0005; setf = 1; cnd = 0;
      step();
      idle(); rst = 1;
      step(); rst = 0;
      chk("R10 reset wakes", active, 1);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule